// File: doc/BRIEF.md
# Tagged Quadword Load Checker

This block finishes a quadword load that doubles as a pointer integrity check. An issue request gives an even destination register number and a 4-bit mask of permitted pointer kinds. The block then waits for the memory response: 128 bits of data plus the tag bit stored with them. When the response arrives, the block writes the two 64-bit halves to an even/odd register pair. In the same cycle it writes one fixed bit of the 16-bit extended exception field. That bit is set only if the data is a tagged pointer whose kind is permitted by the mask.

The pointer kind comes from a 2-bit type field in the top two bits of the quadword. The exception bit is overall bit 41, which is index 9 of the extended field that covers bits 32 to 47.

The controller has two states. S_IDLE accepts issue requests. S_WAIT holds the captured destination and mask until the response arrives. There are three transitions:
- S_IDLE to S_WAIT on a legal issue (even register).
- S_IDLE to S_IDLE on an illegal issue (odd register), which raises a flag.
- S_WAIT to S_IDLE on a valid response, which commits both writes.

Top module: `tagged_qw_load`

## Requirements
- R1: While reset is held and after its release, the block is in S_IDLE, `busy` is 0, and `rf_we`, `xbit_we` and `illegal_op` are 0.
- R2: An issue in S_IDLE with an even `issue_rd` moves to S_WAIT; `busy` is 1 from the next cycle until the response cycle.
- R3: In S_WAIT, a cycle with `resp_valid` high asserts `rf_we` and `xbit_we` together in that same cycle, drives `busy` low in that cycle, and returns to S_IDLE.
- R4: On commit, register `rd` receives `resp_data[127:64]` and register `rd+1` receives `resp_data[63:0]`; `rd` is the captured even number.
- R5: The type field `resp_data[127:126]` encodes 00 system, 01 instruction, 10 space, 11 data. The mask bits are bit 3 system, bit 2 instruction, bit 1 space, bit 0 data; several may be set. `xbit_val` is 1 exactly when `resp_tag` is 1 and the mask bit of the decoded kind is 1.
- R6: With a mask of 0000, `xbit_val` is 0 on commit while both register writes still occur.
- R7: With `resp_tag` at 0, `xbit_val` is 0 on commit whatever the mask and type.
- R8: An issue in S_IDLE with an odd `issue_rd` pulses `illegal_op` in that cycle, stays in S_IDLE, and leads to no write.
- R9: `issue_valid` in S_WAIT is ignored: the captured register and mask are kept. `resp_valid` in S_IDLE produces no write.
- R10: `xbit_sel` reads 9, the index of overall bit 41 within the 16-bit extended field, whenever `xbit_we` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_valid | input | 1 | Load issue request |
| issue_rd | input | 5 | Destination register (must be even) |
| issue_mask | input | 4 | Permitted pointer kinds |
| resp_valid | input | 1 | Memory response valid |
| resp_data | input | 128 | Quadword read from memory |
| resp_tag | input | 1 | Tag bit stored with the quadword |
| busy | output | 1 | Load outstanding |
| illegal_op | output | 1 | Odd destination rejected |
| rf_we | output | 1 | Register pair write enable |
| rf_waddr_even | output | 5 | Even destination index |
| rf_wdata_even | output | 64 | Upper doubleword |
| rf_waddr_odd | output | 5 | Odd destination index |
| rf_wdata_odd | output | 64 | Lower doubleword |
| xbit_we | output | 1 | Extended exception bit write enable |
| xbit_sel | output | 4 | Index within the extended field |
| xbit_val | output | 1 | Value written to the exception bit |

## Verification
The bench sweeps every type code against every mask, with the tag both on and off. A design that reversed the mask bit order or used the wrong type field would set the bit for the wrong kinds. It also covers a zero mask and a cleared tag, where a faulty design would still report a valid pointer or would drop the register writes. Odd destinations, issues arriving while a load is outstanding, and stray responses in idle are all exercised. A design that mishandled these would write registers, corrupt the captured destination, or hold `busy` one cycle too long. Register 30 is used to confirm that the odd half lands in register 31.

// File: rtl/qwl_pkg.sv
package qwl_pkg;
    localparam int unsigned QWL_DW      = 64;
    localparam int unsigned QWL_RAW     = 5;
    localparam int unsigned QWL_NKIND   = 4;
    localparam int unsigned QWL_XW      = 16;
    localparam int unsigned QWL_XPOS    = 9;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } qwl_state_e;
endpackage

// File: rtl/qwl_kind_decode.sv
module qwl_kind_decode #(
    parameter int unsigned NKIND = 4,
    localparam int unsigned TW   = $clog2(NKIND)
) (
    input  logic [TW-1:0]    code_i,
    output logic [NKIND-1:0] kind_oh_o
);
    // type code k maps to mask position NKIND-1-k (first kind in the top bit)
    for (genvar k = 0; k < NKIND; k++) begin : g_kind
        assign kind_oh_o[NKIND-1-k] = (code_i == TW'(k));
    end
endmodule

// File: rtl/qwl_ptr_check.sv
module qwl_ptr_check #(
    parameter int unsigned NKIND = 4,
    localparam int unsigned TW   = $clog2(NKIND)
) (
    input  logic [TW-1:0]    code_i,
    input  logic [NKIND-1:0] mask_i,
    input  logic             tag_i,
    output logic             hit_o
);
    logic [NKIND-1:0] kind_oh;

    qwl_kind_decode #(.NKIND(NKIND)) u_dec (
        .code_i    (code_i),
        .kind_oh_o (kind_oh)
    );

    assign hit_o = tag_i & (|(kind_oh & mask_i));

    always_comb begin
        if (mask_i == '0) begin
            p_zero_mask_r6: assert (!hit_o);
        end
        if (tag_i == 1'b0) begin
            p_untagged_r7: assert (!hit_o);
        end
    end
endmodule

// File: rtl/qwl_split.sv
module qwl_split #(
    parameter int unsigned DW = 64,
    localparam int unsigned QW = 2 * DW
) (
    input  logic [QW-1:0] qw_i,
    output logic [DW-1:0] hi_o,
    output logic [DW-1:0] lo_o
);
    assign hi_o = qw_i[QW-1 -: DW];
    assign lo_o = qw_i[DW-1:0];
endmodule

// File: rtl/tagged_qw_load.sv
module tagged_qw_load
    import qwl_pkg::*;
#(
    parameter int unsigned DW       = QWL_DW,
    parameter int unsigned RAW      = QWL_RAW,
    parameter int unsigned NKIND    = QWL_NKIND,
    parameter int unsigned XW       = QWL_XW,
    parameter int unsigned XPOS     = QWL_XPOS,
    localparam int unsigned QW      = 2 * DW,
    localparam int unsigned TW      = $clog2(NKIND),
    localparam int unsigned XSW     = $clog2(XW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [RAW-1:0]   issue_rd,
    input  logic [NKIND-1:0] issue_mask,
    input  logic             resp_valid,
    input  logic [QW-1:0]    resp_data,
    input  logic             resp_tag,
    output logic             busy,
    output logic             illegal_op,
    output logic             rf_we,
    output logic [RAW-1:0]   rf_waddr_even,
    output logic [DW-1:0]    rf_wdata_even,
    output logic [RAW-1:0]   rf_waddr_odd,
    output logic [DW-1:0]    rf_wdata_odd,
    output logic             xbit_we,
    output logic [XSW-1:0]   xbit_sel,
    output logic             xbit_val
);
    qwl_state_e       state_q, state_d;
    logic [RAW-1:0]   rd_q;
    logic [NKIND-1:0] mask_q;
    logic             hit;
    logic [DW-1:0]    hi_dw, lo_dw;
    logic             issue_ok, issue_bad, commit;

    assign issue_ok  = (state_q == S_IDLE) && issue_valid && !issue_rd[0];
    assign issue_bad = (state_q == S_IDLE) && issue_valid &&  issue_rd[0];
    assign commit    = (state_q == S_WAIT) && resp_valid;

    qwl_ptr_check #(.NKIND(NKIND)) u_chk (
        .code_i (resp_data[QW-1 -: TW]),
        .mask_i (mask_q),
        .tag_i  (resp_tag),
        .hit_o  (hit)
    );

    qwl_split #(.DW(DW)) u_split (
        .qw_i (resp_data),
        .hi_o (hi_dw),
        .lo_o (lo_dw)
    );

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (issue_ok) state_d = S_WAIT;
            S_WAIT: if (resp_valid) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register and captured operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            rd_q    <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (issue_ok) begin
                rd_q   <= issue_rd;
                mask_q <= issue_mask;
            end
        end
    end

    // outputs
    always_comb begin
        busy          = 1'b0;
        illegal_op    = 1'b0;
        rf_we         = 1'b0;
        xbit_we       = 1'b0;
        xbit_val      = 1'b0;
        rf_waddr_even = rd_q;
        rf_waddr_odd  = rd_q | RAW'(1);
        rf_wdata_even = hi_dw;
        rf_wdata_odd  = lo_dw;
        xbit_sel      = XSW'(XPOS);
        unique case (state_q)
            S_IDLE: illegal_op = issue_bad;
            S_WAIT: begin
                busy     = !resp_valid;
                rf_we    = resp_valid;
                xbit_we  = resp_valid;
                xbit_val = resp_valid & hit;
            end
            default: ;
        endcase
    end

    p_reset_idle_r1: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !rf_we);
    p_busy_after_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |=> (state_q == S_WAIT));
    p_commit_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy && !rf_we);
    p_pair_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> xbit_we && !busy);
    p_even_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !rf_waddr_even[0] && rf_waddr_odd[0]);
    p_odd_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |=> !busy && !rf_we);
    p_hold_operands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT) && $past(state_q == S_WAIT) |-> $stable(rd_q) && $stable(mask_q));
endmodule

// File: tb/tagged_qw_load_tb.sv
module tagged_qw_load_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         issue_valid = 1'b0;
    logic [4:0]   issue_rd = '0;
    logic [3:0]   issue_mask = '0;
    logic         resp_valid = 1'b0;
    logic [127:0] resp_data = '0;
    logic         resp_tag = 1'b0;
    logic         busy, illegal_op, rf_we, xbit_we, xbit_val;
    logic [4:0]   rf_waddr_even, rf_waddr_odd;
    logic [63:0]  rf_wdata_even, rf_wdata_odd;
    logic [3:0]   xbit_sel;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural model state
    bit       m_busy = 0;
    int       m_rd = 0;
    bit [3:0] m_mask = 0;

    always #10 clk = ~clk;

    tagged_qw_load u_dut (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_rd(issue_rd),
        .issue_mask(issue_mask), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_tag(resp_tag), .busy(busy), .illegal_op(illegal_op), .rf_we(rf_we),
        .rf_waddr_even(rf_waddr_even), .rf_wdata_even(rf_wdata_even),
        .rf_waddr_odd(rf_waddr_odd), .rf_wdata_odd(rf_wdata_odd),
        .xbit_we(xbit_we), .xbit_sel(xbit_sel), .xbit_val(xbit_val)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit kind_ok(bit [3:0] mask, bit [1:0] ty, bit tag);
        // 00 system->mask[3], 01 instr->mask[2], 10 space->mask[1], 11 data->mask[0]
        return tag && mask[3 - ty];
    endfunction

    // one cycle: drive at negedge, compare mid-low phase, advance model
    task automatic step(bit iv, int rd, bit [3:0] mask, bit rv,
                        logic [127:0] data, bit tag, string req);
        bit e_we, e_busy, e_ill;
        @(negedge clk);
        issue_valid = iv; issue_rd = 5'(rd); issue_mask = mask;
        resp_valid = rv; resp_data = data; resp_tag = tag;
        #5;
        e_busy = m_busy && !rv;
        e_we   = m_busy && rv;
        e_ill  = !m_busy && iv && rd[0];
        chk(req, "busy", 64'(busy), 64'(e_busy));
        chk(req, "rf_we", 64'(rf_we), 64'(e_we));
        chk(req, "xbit_we", 64'(xbit_we), 64'(e_we));
        chk(req, "illegal_op", 64'(illegal_op), 64'(e_ill));
        if (e_we) begin
            chk(req, "even addr", 64'(rf_waddr_even), 64'(m_rd));
            chk(req, "odd addr", 64'(rf_waddr_odd), 64'(m_rd + 1));
            chk(req, "even data", rf_wdata_even, data[127:64]);
            chk(req, "odd data", rf_wdata_odd, data[63:0]);
            chk(req, "xbit_val", 64'(xbit_val), 64'(kind_ok(m_mask, data[127:126], tag)));
            chk("R10", "xbit_sel", 64'(xbit_sel), 64'd9);
        end
        if (!m_busy && iv && !rd[0]) begin
            m_busy = 1; m_rd = rd; m_mask = mask;
        end else if (m_busy && rv) begin
            m_busy = 0;
        end
    endtask

    function automatic logic [127:0] mkq(bit [1:0] ty, int seed);
        return {ty, 62'(seed * 32'h9e3779b1), 32'(seed + 7), 32'hc0de0000 + 32'(seed)};
    endfunction

    initial begin
        #200_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: during reset
        #15;
        chk("R1", "busy in reset", 64'(busy), 0);
        chk("R1", "rf_we in reset", 64'(rf_we), 0);
        chk("R1", "xbit_we in reset", 64'(xbit_we), 0);
        @(negedge clk); rst_n = 1'b1;
        step(0, 0, 0, 0, '0, 0, "R1");

        // R2/R3/R5: instruction pointer allowed by 0110
        step(1, 4, 4'b0110, 0, '0, 0, "R2");
        step(0, 0, 0, 0, '0, 0, "R2");
        step(0, 0, 0, 1, mkq(2'b01, 1), 1, "R3");
        step(0, 0, 0, 0, '0, 0, "R3");
        // R5: system pointer not allowed by 0110
        step(1, 6, 4'b0110, 0, '0, 0, "R5");
        step(0, 0, 0, 1, mkq(2'b00, 2), 1, "R5");
        // R6: zero mask, writes still occur
        step(1, 8, 4'b0000, 0, '0, 0, "R6");
        step(0, 0, 0, 1, mkq(2'b10, 3), 1, "R6");
        // R7: untagged
        step(1, 10, 4'b1111, 0, '0, 0, "R7");
        step(0, 0, 0, 1, mkq(2'b11, 4), 0, "R7");
        // R5: full sweep of types, masks and tag
        for (int m = 0; m < 16; m++) begin
            for (int t = 0; t < 4; t++) begin
                for (int g = 0; g < 2; g++) begin
                    step(1, 2 * ((m + t) % 16), 4'(m), 0, '0, 0, "R5");
                    step(0, 0, 0, 1, mkq(2'(t), m * 8 + t * 2 + g), g[0], "R5");
                end
            end
        end
        // R8: odd destination rejected, later response writes nothing
        step(1, 7, 4'b1111, 0, '0, 0, "R8");
        step(0, 0, 0, 1, mkq(2'b00, 5), 1, "R8");
        step(1, 31, 4'b1000, 0, '0, 0, "R8");
        // R9: stray response in idle, issue while waiting ignored
        step(0, 0, 0, 1, mkq(2'b01, 6), 1, "R9");
        step(1, 12, 4'b0001, 0, '0, 0, "R9");
        step(1, 20, 4'b1000, 0, '0, 0, "R9");
        step(1, 3, 4'b1000, 0, '0, 0, "R9");
        step(0, 0, 0, 1, mkq(2'b11, 7), 1, "R9");
        step(0, 0, 0, 1, mkq(2'b00, 8), 1, "R9");
        // R4: highest even register pair
        step(1, 30, 4'b0010, 0, '0, 0, "R4");
        step(0, 0, 0, 1, mkq(2'b10, 9), 1, "R4");
        // R3: back-to-back issue right after commit
        step(1, 0, 4'b1000, 0, '0, 0, "R3");
        step(0, 0, 0, 1, mkq(2'b00, 10), 1, "R3");
        step(1, 2, 4'b0100, 0, '0, 0, "R3");
        step(0, 0, 0, 1, mkq(2'b01, 11), 1, "R3");
        step(0, 0, 0, 0, '0, 0, "R3");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule